// File: doc/BRIEF.md
# Receiver Interrupt Aggregation Controller

This block gathers eight status conditions from a serial digital audio receiver and turns them into two interrupt pins and an 8-bit status word for a host. Four conditions are level flags that follow their inputs as they change: loss of lock, compressed-stream detection, validity flag and non-audio flag. The other four are event flags: parity/biphase error, sample-rate or emphasis change, Q-subcode sync and channel-status change. Each event flag stays set until the host reads status. Mask bits take any condition off both pins without touching its status bit.

The stretched pin keeps asserting for a programmable number of clock cycles after its last active source. The immediate pin drops in the same cycle its sources clear. While locked, both pins see all eight unmasked sources. While unlocked, the stretched pin sees only unlock and parity error, and the immediate pin sees only stream, validity and non-audio. A disabled PLL silences both pins. The block also gates the recovered sample word. It outputs zero while unlocked, repeats the last good word on a parity error, and otherwise passes the received word through.

Top module: `rx_irq_agg`

## Requirements
- R1: `status_o` bit 0 is high when `locked_i` is low. Bits 2, 3 and 4 equal `stream_det_i`, `valid_flag_i` and `non_audio_i` in the same cycle.
- R2: Status bits 1 (parity), 5 (rate change), 6 (Q-subcode) and 7 (channel status) are set the cycle after their input pulses high. They hold until a cycle with `stat_rd_i` high, and they read 0 after it.
- R3: If an event input and `stat_rd_i` are high in the same cycle, that event's status bit reads 1 afterwards.
- R4: `mask_i` never changes `status_o`.
- R5: A condition whose `mask_i` bit is 1 has no effect on either pin.
- R6: While locked and with `pll_en_i` high, `irq_imm_o` is the combinational OR of all unmasked sources. It rises and falls in the same cycle as those sources.
- R7: An event input drives the pin logic from the next cycle. It keeps driving it through the first cycle in which `subframe_i` is high, and stops after that edge, unless the event fires again.
- R8: `irq_hold_o` rises one cycle after any routed unmasked source is active. It stays high for exactly N cycles after the last active cycle. `hold_sel_i` sets N: 0=512, 1=1024, 2=2048, 3=4096.
- R9: While `locked_i` is low, `irq_hold_o` draws only from unlock and parity, and `irq_imm_o` draws only from stream, validity and non-audio.
- R10: While `pll_en_i` is low, both pins are low in the same cycle. The hold count is discarded.
- R11: `sample_o` updates one cycle after its inputs. It becomes 0 while unlocked. When locked with `sample_vld_i` high, it repeats its previous value if `par_err_i` is high and otherwise loads `sample_i`.
- R12: In reset, the event status bits, both pins and `sample_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_en_i | input | 1 | PLL enabled; low forces pins low |
| locked_i | input | 1 | Receiver lock state |
| par_err_i | input | 1 | Parity/biphase error strobe |
| stream_det_i | input | 1 | Compressed-stream detect level |
| valid_flag_i | input | 1 | Validity flag level |
| non_audio_i | input | 1 | Non-audio flag level |
| rate_chg_i | input | 1 | Rate/emphasis change strobe |
| qsub_sync_i | input | 1 | Q-subcode sync strobe |
| cstat_chg_i | input | 1 | Channel-status change strobe |
| stat_rd_i | input | 1 | Status read strobe, clears event bits |
| subframe_i | input | 1 | Sub-frame boundary strobe |
| mask_i | input | 8 | Per-condition pin mask, 1 = masked |
| hold_sel_i | input | 2 | Stretch length select |
| sample_vld_i | input | 1 | Received sample valid |
| sample_i | input | DW | Received sample word |
| irq_hold_o | output | 1 | Stretched interrupt pin |
| irq_imm_o | output | 1 | Immediate interrupt pin |
| status_o | output | 8 | Status word |
| sample_o | output | DW | Gated sample word |

## Verification
The bound checker watches, on every cycle, the local rules that hold at any time. These are the read/set priority of the parity bit, its retention between reads, and silence of both pins with the PLL off. They also include a fully masked immediate pin, the stretched pin following any locked immediate assertion, and a zeroed sample while unlocked. The counts themselves can only be shown by the bench's scenarios. These are the exact stretch length for each select code, the end of an event's pulse at the sub-frame boundary, the changed routing after unlock, and repeat-on-error of the sample word. The bench runs these against its model over directed and random traffic.

// File: rtl/rx_irq_pkg.sv
`timescale 1ns/1ps
package rx_irq_pkg;
  localparam int unsigned NUM_EVT = 8;

  typedef enum logic [2:0] {
    EV_UNLOCK   = 3'd0,
    EV_PARITY   = 3'd1,
    EV_STREAM   = 3'd2,
    EV_VALID    = 3'd3,
    EV_NONAUDIO = 3'd4,
    EV_RATE     = 3'd5,
    EV_QSUB     = 3'd6,
    EV_CSTAT    = 3'd7
  } evt_idx_e;

  // clear-on-read events
  localparam logic [NUM_EVT-1:0] STICKY_SET      = 8'b1110_0010;
  // routing while unlocked
  localparam logic [NUM_EVT-1:0] UNLK_HOLD_ROUTE = 8'b0000_0011;
  localparam logic [NUM_EVT-1:0] UNLK_IMM_ROUTE  = 8'b0001_1100;
endpackage

// File: rtl/rx_irq_flags.sv
`timescale 1ns/1ps
module rx_irq_flags #(
  parameter int unsigned     N      = 8,
  parameter logic [N-1:0]    STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         rd_i,
  input  logic         sf_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] src_o
);
  for (genvar i = 0; i < N; i++) begin : g_evt
    if (STICKY[i]) begin : g_sticky
      logic flag_q, pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q  <= 1'b0;
          pulse_q <= 1'b0;
        end else begin
          flag_q  <= evt_i[i] | (flag_q & ~rd_i);   // R3: set beats read
          pulse_q <= evt_i[i] | (pulse_q & ~sf_i);  // R7: lasts to sub-frame
        end
      end
      assign status_o[i] = flag_q;
      assign src_o[i]    = pulse_q;
    end else begin : g_live
      assign status_o[i] = evt_i[i];
      assign src_o[i]    = evt_i[i];
    end
  end
endmodule

// File: rtl/rx_irq_router.sv
`timescale 1ns/1ps
module rx_irq_router #(
  parameter int unsigned  N          = 8,
  parameter logic [N-1:0] HOLD_UNLK  = '1,
  parameter logic [N-1:0] IMM_UNLK   = '1
) (
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] mask_i,
  input  logic         locked_i,
  input  logic         pll_en_i,
  output logic         hold_req_o,
  output logic         imm_o
);
  logic [N-1:0] live, route_hold, route_imm;

  assign live       = src_i & ~mask_i;              // R5
  assign route_hold = locked_i ? '1 : HOLD_UNLK;    // R9
  assign route_imm  = locked_i ? '1 : IMM_UNLK;
  assign hold_req_o = pll_en_i & |(live & route_hold);
  assign imm_o      = pll_en_i & |(live & route_imm); // R6, R10
endmodule

// File: rtl/rx_irq_stretch.sv
`timescale 1ns/1ps
module rx_irq_stretch #(
  parameter int unsigned HOLD_BASE = 512,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pin_o
);
  localparam int unsigned MAX_HOLD = HOLD_BASE << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD);

  logic [CNT_W-1:0] cnt_q, reload;
  logic             pin_q;

  assign reload = CNT_W'((HOLD_BASE << sel_i) - 1);  // R8

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      pin_q <= 1'b0;
      cnt_q <= '0;
    end else if (req_i) begin
      pin_q <= 1'b1;
      cnt_q <= reload;
    end else if (cnt_q != '0) begin
      pin_q <= 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end else begin
      pin_q <= 1'b0;
    end
  end

  assign pin_o = pin_q & en_i;  // R10
endmodule

// File: rtl/rx_irq_sdata.sv
`timescale 1ns/1ps
module rx_irq_sdata #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          locked_i,
  input  logic          vld_i,
  input  logic          err_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           data_o <= '0;
    else if (!locked_i)    data_o <= '0;     // R11
    else if (vld_i && !err_i) data_o <= data_i;
  end
endmodule

// File: rtl/rx_irq_agg.sv
`timescale 1ns/1ps
module rx_irq_agg
  import rx_irq_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned HOLD_BASE = 512
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pll_en_i,
  input  logic                  locked_i,
  input  logic                  par_err_i,
  input  logic                  stream_det_i,
  input  logic                  valid_flag_i,
  input  logic                  non_audio_i,
  input  logic                  rate_chg_i,
  input  logic                  qsub_sync_i,
  input  logic                  cstat_chg_i,
  input  logic                  stat_rd_i,
  input  logic                  subframe_i,
  input  logic [NUM_EVT-1:0]    mask_i,
  input  logic [1:0]            hold_sel_i,
  input  logic                  sample_vld_i,
  input  logic [DW-1:0]         sample_i,
  output logic                  irq_hold_o,
  output logic                  irq_imm_o,
  output logic [NUM_EVT-1:0]    status_o,
  output logic [DW-1:0]         sample_o
);
  logic [NUM_EVT-1:0] evt, src;
  logic               hold_req;

  always_comb begin
    evt              = '0;
    evt[EV_UNLOCK]   = ~locked_i;   // R1
    evt[EV_PARITY]   = par_err_i;
    evt[EV_STREAM]   = stream_det_i;
    evt[EV_VALID]    = valid_flag_i;
    evt[EV_NONAUDIO] = non_audio_i;
    evt[EV_RATE]     = rate_chg_i;
    evt[EV_QSUB]     = qsub_sync_i;
    evt[EV_CSTAT]    = cstat_chg_i;
  end

  rx_irq_flags #(.N(NUM_EVT), .STICKY(STICKY_SET)) i_flags (
    .clk_i, .rst_ni, .evt_i(evt), .rd_i(stat_rd_i), .sf_i(subframe_i),
    .status_o, .src_o(src)
  );

  rx_irq_router #(.N(NUM_EVT), .HOLD_UNLK(UNLK_HOLD_ROUTE), .IMM_UNLK(UNLK_IMM_ROUTE)) i_router (
    .src_i(src), .mask_i, .locked_i, .pll_en_i,
    .hold_req_o(hold_req), .imm_o(irq_imm_o)
  );

  rx_irq_stretch #(.HOLD_BASE(HOLD_BASE), .SEL_W(2)) i_stretch (
    .clk_i, .rst_ni, .en_i(pll_en_i), .req_i(hold_req), .sel_i(hold_sel_i),
    .pin_o(irq_hold_o)
  );

  rx_irq_sdata #(.DW(DW)) i_sdata (
    .clk_i, .rst_ni, .locked_i, .vld_i(sample_vld_i), .err_i(par_err_i),
    .data_i(sample_i), .data_o(sample_o)
  );
endmodule

// File: rtl/rx_irq_agg_chk.sv
`timescale 1ns/1ps
module rx_irq_agg_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pll_en_i,
  input logic          locked_i,
  input logic          par_err_i,
  input logic          stat_rd_i,
  input logic [7:0]    mask_i,
  input logic          irq_hold_o,
  input logic          irq_imm_o,
  input logic [7:0]    status_o,
  input logic [DW-1:0] sample_o
);
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_i |=> status_o[1]);

  a_r2_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !stat_rd_i) |=> status_o[1]);

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !par_err_i) |=> !status_o[1]);

  a_r10_pll_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_i |-> (!irq_hold_o && !irq_imm_o));

  a_r5_full_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 8'hFF) |-> !irq_imm_o);

  a_r8_hold_follows_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_i && locked_i && irq_imm_o) |=> (irq_hold_o || !pll_en_i));

  a_r11_unlock_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> (sample_o == '0));
endmodule

bind rx_irq_agg rx_irq_agg_chk #(.DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pll_en_i(pll_en_i), .locked_i(locked_i),
  .par_err_i(par_err_i), .stat_rd_i(stat_rd_i), .mask_i(mask_i),
  .irq_hold_o(irq_hold_o), .irq_imm_o(irq_imm_o), .status_o(status_o),
  .sample_o(sample_o)
);

// File: tb/test_rx_irq_agg.sv
`timescale 1ns/1ps
module test_rx_irq_agg;
  localparam int DW = 16;
  localparam logic [7:0] STK = 8'hE2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pll_en, locked, par, stream, valid, nonaudio, rate, qsub, cstat, rd, sf, vld;
  logic [7:0] mask;
  logic [1:0] hsel;
  logic [DW-1:0] smp;
  logic irq_hold_o, irq_imm_o;
  logic [7:0] status_o;
  logic [DW-1:0] sample_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_stk, m_pul;
  logic m_hold;
  int m_cnt;
  logic [DW-1:0] m_data;

  always #10 clk = ~clk;

  rx_irq_agg #(.DW(DW)) i_rx_irq_agg (
    .clk_i(clk), .rst_ni, .pll_en_i(pll_en), .locked_i(locked), .par_err_i(par),
    .stream_det_i(stream), .valid_flag_i(valid), .non_audio_i(nonaudio),
    .rate_chg_i(rate), .qsub_sync_i(qsub), .cstat_chg_i(cstat), .stat_rd_i(rd),
    .subframe_i(sf), .mask_i(mask), .hold_sel_i(hsel), .sample_vld_i(vld),
    .sample_i(smp), .irq_hold_o, .irq_imm_o, .status_o, .sample_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ev_vec();
    return {cstat, qsub, rate, nonaudio, valid, stream, par, ~locked};
  endfunction

  function automatic logic [7:0] src_vec();
    return (ev_vec() & ~STK) | (m_pul & STK);
  endfunction

  function automatic logic exp_imm();
    logic [7:0] r = locked ? 8'hFF : 8'h1C;
    return pll_en & |(src_vec() & ~mask & r);
  endfunction

  function automatic logic hold_req();
    logic [7:0] r = locked ? 8'hFF : 8'h03;
    return pll_en & |(src_vec() & ~mask & r);
  endfunction

  task automatic check_all();
    chk("R1 live status", 32'(status_o & ~STK), 32'(ev_vec() & ~STK));
    chk("R2 event status", 32'(status_o & STK), 32'(m_stk & STK));
    chk("R6 immediate pin", 32'(irq_imm_o), 32'(exp_imm()));
    chk("R8 stretched pin", 32'(irq_hold_o), 32'(m_hold & pll_en));
    chk("R11 sample out", 32'(sample_o), 32'(m_data));
  endtask

  task automatic model_update();
    logic hr = hold_req();
    if (!pll_en) begin m_hold = 0; m_cnt = 0; end
    else if (hr) begin m_hold = 1; m_cnt = (512 << hsel) - 1; end
    else if (m_cnt != 0) begin m_hold = 1; m_cnt--; end
    else m_hold = 0;
    m_stk = (ev_vec() & STK) | (m_stk & ~{8{rd}});
    m_pul = (ev_vec() & STK) | (m_pul & ~{8{sf}});
    if (!locked) m_data = '0;
    else if (vld && !par) m_data = smp;
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    pll_en = 1; locked = 1; par = 0; stream = 0; valid = 0; nonaudio = 0;
    rate = 0; qsub = 0; cstat = 0; rd = 0; sf = 0; vld = 0; mask = '0;
  endtask

  task automatic hold_len(input logic [1:0] s);
    int cnt = 0;
    idle(); hsel = s; rd = 1; sf = 1; step(); rd = 0; sf = 0;
    for (int g = 0; g < 5000 && irq_hold_o; g++) step();
    stream = 1; step(); stream = 0;
    for (int g = 0; g < 5000; g++) begin
      #1;
      if (!irq_hold_o) break;
      cnt++;
      step();
    end
    chk("R8 hold length", 32'(cnt), 32'(512 << s));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    idle(); hsel = 2'd1; smp = '0;
    m_stk = '0; m_pul = '0; m_hold = 0; m_cnt = 0; m_data = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R12 reset event bits", 32'(status_o & STK), 0);
    chk("R12 reset hold pin", 32'(irq_hold_o), 0);
    chk("R12 reset imm pin", 32'(irq_imm_o), 0);
    chk("R12 reset sample", 32'(sample_o), 0);
    rst_ni = 1;
    @(negedge clk);

    // R1 / R6: live flag and combinational pin
    valid = 1; #1;
    chk("R1 validity bit", 32'(status_o[3]), 1);
    chk("R6 imm rises same cycle", 32'(irq_imm_o), 1);
    valid = 0; #1;
    chk("R6 imm falls same cycle", 32'(irq_imm_o), 0);
    step();

    // R3 then R2
    par = 1; rd = 1; step(); par = 0; rd = 0; #1;
    chk("R3 set beats read", 32'(status_o[1]), 1);
    step(); #1;
    chk("R2 held without read", 32'(status_o[1]), 1);
    rd = 1; step(); rd = 0; #1;
    chk("R2 read clears", 32'(status_o[1]), 0);

    // R4 / R5
    sf = 1; step(); sf = 0;
    mask = 8'hFF; rate = 1; stream = 1; #1;
    chk("R5 masked imm", 32'(irq_imm_o), 0);
    step(); rate = 0; #1;
    chk("R4 rate bit despite mask", 32'(status_o[5]), 1);
    chk("R4 stream bit despite mask", 32'(status_o[2]), 1);
    chk("R5 masked imm after event", 32'(irq_imm_o), 0);
    step();

    // R7
    idle(); sf = 1; step(); sf = 0;
    qsub = 1; step(); qsub = 0;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R7 pulse held", 32'(irq_imm_o), 1);
      step();
    end
    sf = 1; #1 chk("R7 pulse through boundary", 32'(irq_imm_o), 1);
    step(); sf = 0; #1;
    chk("R7 pulse ends", 32'(irq_imm_o), 0);
    step();

    // R9
    idle(); locked = 0; stream = 1; #1;
    chk("R9 imm carries stream", 32'(irq_imm_o), 1);
    step(); stream = 0; rate = 1; step(); rate = 0; #1;
    chk("R9 imm excludes rate", 32'(irq_imm_o), 0);
    chk("R9 hold carries unlock", 32'(irq_hold_o), 1);
    step();

    // R10
    pll_en = 0; stream = 1; #1;
    chk("R10 hold pin off", 32'(irq_hold_o), 0);
    chk("R10 imm pin off", 32'(irq_imm_o), 0);
    step();

    // R11
    idle(); vld = 1; smp = 16'h1234; step(); #1;
    chk("R11 pass through", 32'(sample_o), 32'h1234);
    par = 1; smp = 16'hABCD; step(); #1;
    chk("R11 repeat on error", 32'(sample_o), 32'h1234);
    par = 0; locked = 0; vld = 0; step(); #1;
    chk("R11 zero unlocked", 32'(sample_o), 0);
    step();

    // R8 lengths
    for (int s = 0; s < 4; s++) hold_len(2'(s));

    // random traffic
    idle();
    for (int n = 0; n < 4000; n++) begin
      if (n % 256 == 0) begin
        mask = 8'($urandom & $urandom & $urandom);
        hsel = 2'($urandom);
      end
      locked   = ($urandom % 100) < 96;
      pll_en   = ($urandom % 100) < 98;
      par      = ($urandom % 100) < 4;
      stream   = ($urandom % 100) < 3;
      valid    = ($urandom % 100) < 3;
      nonaudio = ($urandom % 100) < 3;
      rate     = ($urandom % 100) < 2;
      qsub     = ($urandom % 100) < 2;
      cstat    = ($urandom % 100) < 2;
      rd       = ($urandom % 10) == 0;
      sf       = ($urandom % 8) == 0;
      vld      = ($urandom % 3) == 0;
      smp      = DW'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule